// File: doc/BRIEF.md
# Register-Configured SPI Master

This block is an SPI master peripheral that software controls through a small synchronous register bus. Software sets the clock polarity, clock phase, bit order and SCK rate. A write to the data register then starts one 8-bit full-duplex exchange. The byte received during that exchange becomes what the data address reads back, so reading a slave means writing a dummy byte first. The serial clock stays quiet until such a write.

How the slave-select line behaves depends on two control bits. With both bits set, the block owns the line and drives it low for each exchange. With only the fault bit set, the line is an input, and pulling it low flags a mode fault and drops the block out of master mode. With the fault bit clear, the block leaves the line alone.

Status reports exchange-complete, transmitter-empty and mode-fault. Two interrupt outputs can be enabled from these flags. The bus is single-cycle: a write takes effect at the clock edge where it is presented, and read data appears on `reg_rdata` one clock after the request.

Top module: `spi_master_regs`

## Requirements
- R1: SCK never toggles until the data address (4) is written while control-1 bits 0 (system enable) and 1 (master) are both set. Each accepted write produces exactly 16 SCK edges, which make 8 bit periods.
- R2: While no exchange runs, SCK rests at the level of control-1 bit 2 (polarity).
- R3: Control-1 bit 3 (phase). With a value of 0, MOSI holds the first bit before the first edge, MISO is sampled on odd-numbered edges and MOSI changes on even-numbered edges. With a value of 1, MOSI changes on odd-numbered edges and MISO is sampled on even-numbered edges.
- R4: Control-1 bit 4 selects the bit order for both directions: 0 sends MSB first, 1 sends LSB first. After an exchange, a read of address 4 returns the byte received on MISO.
- R5: The baud register (address 2) holds P in bits 6:4 and R in bits 2:0. One SCK period lasts (P+1)·2^(R+1) bus clocks, with each half of the period taking half that count.
- R6: With control-2 bit 0 (fault enable) and control-1 bit 5 (select output enable) both set, the block is in auto mode. In master mode with the system enabled, `ssel_oe` is 1 and `ssel_o` is low during the exchange and high otherwise.
- R7: With fault enable set and control-1 bit 5 clear, `ssel_oe` is 0. A low on `ssel_i` while enabled in master mode sets status bit 4 (mode fault), clears control-1 bit 1 (master) and aborts any exchange.
- R8: With fault enable clear, `ssel_oe` is 0, `ssel_o` stays high and `ssel_i` has no effect.
- R9: `sck_oe` is 1 exactly when system enable and master are both set.
- R10: Status (address 3) bit 7 sets when an exchange ends. A data read clears it only if a status read made while the bit was set came first. Status bit 4 clears when a status read made while it was set is followed by a control-1 write.
- R11: Status bit 5 (transmitter empty) is 1 whenever no exchange runs. A data write made during an exchange is dropped.
- R12: Clearing system enable aborts an exchange. SCK returns to its idle level, `ssel_o` returns high and status bit 7 stays clear.
- R13: `irq_o` equals control-1 bit 6 AND (status bit 7 OR status bit 4). `irq_tx_o` equals control-1 bit 7 AND status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | 0 ctrl1, 1 ctrl2, 2 baud, 3 status, 4 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one clock after the request |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ssel_o | output | 1 | Slave-select drive value |
| ssel_oe | output | 1 | Slave-select output enable |
| ssel_i | input | 1 | Slave-select pin level |
| irq_o | output | 1 | Exchange-complete / fault interrupt |
| irq_tx_o | output | 1 | Transmitter-empty interrupt |

## Verification
- An edge counter that drifts by one leaves a byte shifted by one bit at the slave model. It also changes the SCK toggle count, and either shows up at the end of that same exchange.
- A wrong idle level or a skipped phase shows up on SCK or MOSI within one half period.
- A stuck flag-clearing state leaves status bit 7 or bit 4 set on the very next status read. It also holds `irq_o` high.
- A select controller in the wrong configuration shows up on `ssel_oe` or `ssel_o` within a clock of the control write.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL1 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL2 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BAUD  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DATA  = 3'd4;

  typedef struct packed {
    logic tx_irq_en;  // bit 7
    logic irq_en;     // bit 6
    logic auto_ssel;  // bit 5
    logic lsb_first;  // bit 4
    logic cpha;       // bit 3
    logic cpol;       // bit 2
    logic master;     // bit 1
    logic sys_en;     // bit 0
  } ctrl1_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clear,
  input  logic [PRE_W-1:0]  presc,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = PRE_W + (1 << RATE_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;

  always_comb begin
    half = CNT_W'(presc) + CNT_W'(1);
    half = half << rate;
  end

  assign tick = run && (cnt == half - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear || !run || tick) cnt <= '0;
    else                              cnt <= cnt + CNT_W'(1);
  end

  assert_half_bound_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < half));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_byte_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EC_W  = $clog2(EDGES + 1);

  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [EC_W-1:0]   edge_cnt;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, rx_final, ld;
  logic              lead, sample_now, last_edge;

  assign ld         = lsb_first ? flip(tx_byte) : tx_byte;
  assign lead       = ~edge_cnt[0];
  assign sample_now = (lead != cpha);
  assign last_edge  = (edge_cnt == EC_W'(EDGES - 1));
  assign rx_next    = {rx_sh[DATA_W-2:0], miso_i};
  assign rx_final   = sample_now ? rx_next : rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      edge_cnt  <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sck_o     <= 1'b0;
      mosi_o    <= 1'b0;
      done_o    <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (abort) begin
        busy_o   <= 1'b0;
        edge_cnt <= '0;
        sck_o    <= cpol;
      end else if (start) begin
        busy_o   <= 1'b1;
        edge_cnt <= '0;
        tx_sh    <= ld;
        sck_o    <= cpol;
        if (!cpha) mosi_o <= ld[DATA_W-1];
      end else if (busy_o && tick) begin
        edge_cnt <= edge_cnt + EC_W'(1);
        sck_o    <= ~sck_o;
        if (sample_now) begin
          rx_sh <= rx_next;
        end else if (cpha) begin
          mosi_o <= tx_sh[DATA_W-1];
          tx_sh  <= tx_sh << 1;
        end else if (!last_edge) begin
          mosi_o <= tx_sh[DATA_W-2];
          tx_sh  <= tx_sh << 1;
        end
        if (last_edge) begin
          busy_o    <= 1'b0;
          done_o    <= 1'b1;
          rx_byte_o <= lsb_first ? flip(rx_final) : rx_final;
        end
      end else if (!busy_o) begin
        sck_o <= cpol;
      end
    end
  end

  assert_edge_bound_R1: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (edge_cnt < EC_W'(EDGES)));
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && $stable(cpol)) |-> (sck_o == cpol));
endmodule

// File: rtl/spi_ssel_ctl.sv
module spi_ssel_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fault_en,
  input  logic auto_en,
  input  logic active,
  input  logic start,
  input  logic busy,
  input  logic ssel_i,
  output logic ssel_o,
  output logic ssel_oe,
  output logic fault_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   auto_mode;

  assign auto_mode = fault_en && auto_en && active;
  assign fault_o   = fault_en && !auto_en && active && !sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      ssel_o  <= 1'b1;
      ssel_oe <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], ssel_i};
      ssel_oe <= auto_mode;
      ssel_o  <= !(auto_mode && (start || busy));
    end
  end

  assert_auto_low_R6: assert property (@(posedge clk) disable iff (rst)
    (auto_mode && $stable(auto_mode) && busy) |-> !ssel_o);
  assert_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!fault_en) |-> (!ssel_oe && ssel_o));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int PRE_W  = 3,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ssel_o,
  output logic              ssel_oe,
  input  logic              ssel_i,
  output logic              irq_o,
  output logic              irq_tx_o
);
  ctrl1_t            ctrl1;
  logic              fault_en;
  logic [PRE_W-1:0]  presc;
  logic [RATE_W-1:0] rate;
  logic              done_flag, fault_flag, arm_done, arm_fault;
  logic              busy, done_p, tick, fault_p, active, start, abort;
  logic              wr, rd;
  logic [BYTE_W-1:0] rx_byte, status;

  assign wr     = reg_en && reg_we;
  assign rd     = reg_en && !reg_we;
  assign active = ctrl1.sys_en && ctrl1.master;
  assign abort  = !active || fault_p;
  assign start  = wr && (reg_addr == ADR_DATA) && active && !busy && !fault_p;
  assign status = {done_flag, 1'b0, !busy, fault_flag, 4'b0};

  spi_baud_gen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_baud (
    .clk(clk), .rst(rst), .run(busy), .clear(start),
    .presc(presc), .rate(rate), .tick(tick)
  );

  spi_shift_engine #(.DATA_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .tick(tick),
    .tx_byte(reg_wdata), .cpol(ctrl1.cpol), .cpha(ctrl1.cpha),
    .lsb_first(ctrl1.lsb_first), .miso_i(miso_i), .busy_o(busy),
    .sck_o(sck_o), .mosi_o(mosi_o), .done_o(done_p), .rx_byte_o(rx_byte)
  );

  spi_ssel_ctl #(.SYNC_STAGES(2)) u_ssel (
    .clk(clk), .rst(rst), .fault_en(fault_en), .auto_en(ctrl1.auto_ssel),
    .active(active), .start(start), .busy(busy), .ssel_i(ssel_i),
    .ssel_o(ssel_o), .ssel_oe(ssel_oe), .fault_o(fault_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl1      <= '0;
      fault_en   <= 1'b0;
      presc      <= '0;
      rate       <= '0;
      done_flag  <= 1'b0;
      fault_flag <= 1'b0;
      arm_done   <= 1'b0;
      arm_fault  <= 1'b0;
    end else begin
      if (wr && reg_addr == ADR_CTRL1) begin
        ctrl1 <= ctrl1_t'(reg_wdata);
        if (arm_fault) begin
          fault_flag <= 1'b0;
          arm_fault  <= 1'b0;
        end
      end
      if (wr && reg_addr == ADR_CTRL2) fault_en <= reg_wdata[0];
      if (wr && reg_addr == ADR_BAUD) begin
        presc <= reg_wdata[4 +: PRE_W];
        rate  <= reg_wdata[0 +: RATE_W];
      end
      if (rd && reg_addr == ADR_STAT) begin
        if (done_flag)  arm_done  <= 1'b1;
        if (fault_flag) arm_fault <= 1'b1;
      end
      if (rd && reg_addr == ADR_DATA && arm_done) begin
        done_flag <= 1'b0;
        arm_done  <= 1'b0;
      end
      if (done_p) done_flag <= 1'b1;
      if (fault_p) begin
        fault_flag   <= 1'b1;
        ctrl1.master <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      sck_oe    <= 1'b0;
      irq_o     <= 1'b0;
      irq_tx_o  <= 1'b0;
    end else begin
      sck_oe   <= active;
      irq_o    <= ctrl1.irq_en && (done_flag || fault_flag);
      irq_tx_o <= ctrl1.tx_irq_en && !busy;
      if (rd) begin
        case (reg_addr)
          ADR_CTRL1: reg_rdata <= ctrl1;
          ADR_CTRL2: reg_rdata <= {7'b0, fault_en};
          ADR_BAUD:  reg_rdata <= {1'b0, presc, 1'b0, rate};
          ADR_STAT:  reg_rdata <= status;
          ADR_DATA:  reg_rdata <= rx_byte;
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  assert_fault_exits_master_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_flag) |-> !ctrl1.master);
  assert_abort_no_done_R12: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl1.sys_en) |=> !done_p);
endmodule

// File: tb/spi_master_regs_test.sv
`timescale 1ns/1ps
module spi_master_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sck, sck_oe, mosi, ssel_o, ssel_oe, irq, irq_tx;
  logic miso = 1'b0, ssel_i = 1'b1;

  always #4 clk = ~clk;

  spi_master_regs uut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck), .sck_oe(sck_oe),
    .mosi_o(mosi), .miso_i(miso), .ssel_o(ssel_o), .ssel_oe(ssel_oe),
    .ssel_i(ssel_i), .irq_o(irq), .irq_tx_o(irq_tx)
  );

  int checks = 0, errors = 0;
  int tog = 0;
  bit mon_en = 0, m_cpha = 0, m_lsb = 0;
  int m_edge = 0, sb = 0;
  logic [7:0] sl_byte = '0, got = '0;
  logic [7:0] exp_q[$];
  logic ss_mid = 1'b1;
  realtime t1 = 0, t3 = 0;
  logic [7:0] v;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic sbit(input int n);
    return m_lsb ? sl_byte[n] : sl_byte[7-n];
  endfunction

  always @(sck) tog++;

  // scoreboard monitor: plays the slave and compares MOSI bytes with the queue
  always @(sck) begin
    if (mon_en) begin
      #1;
      m_edge++;
      if (m_edge == 1) begin t1 = $realtime; ss_mid = ssel_o; end
      if (m_edge == 3) t3 = $realtime;
      if ((m_edge % 2 == 1) != m_cpha) got = m_lsb ? {mosi, got[7:1]} : {got[6:0], mosi};
      else if (m_edge < 16) begin miso = sbit(sb); sb++; end
      if (m_edge == 16) begin
        chk("R3 mosi byte at slave", got, exp_q.pop_front());
        mon_en = 0;
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); reg_en = 0; d = reg_rdata;
  endtask

  task automatic cfg(input bit pol, input bit pha, input bit lsb, input bit aut,
                     input bit ie, input bit tie);
    m_cpha = pha; m_lsb = lsb;
    wr(3'd0, {tie, ie, aut, lsb, pha, pol, 1'b1, 1'b1});
  endtask

  task automatic wait_mon();
    for (int i = 0; i < 20000 && mon_en; i++) @(negedge clk);
    if (mon_en) begin
      checks++; errors++; mon_en = 0;
      $display("FAIL R1 exchange never finished actual=busy expected=done");
    end
  endtask

  task automatic launch(input logic [7:0] tx, input logic [7:0] sl);
    sl_byte = sl; got = '0; m_edge = 0; sb = 0;
    if (!m_cpha) begin miso = sbit(0); sb = 1; end
    exp_q.push_back(tx);
    mon_en = 1;
    wr(3'd4, tx);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input bit rdback);
    launch(tx, sl);
    wait_mon();
    repeat (3) @(negedge clk);
    if (rdback) begin
      rd(3'd3, v); chk("R10 done bit after exchange", v[7], 1);
      rd(3'd4, v); chk("R4 received byte", v, sl);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    chk("reset sck", sck, 0);
    chk("reset ssel_o", ssel_o, 1);
    chk("reset ssel_oe", ssel_oe, 0);
    chk("R9 reset sck_oe", sck_oe, 0);
    rd(3'd0, v); chk("reset ctrl1", v, 8'h00);
    rd(3'd3, v); chk("R11 reset status empty", v, 8'h20);

    wr(3'd2, 8'h20);       // P=2 R=0 -> divide by 6
    wr(3'd1, 8'h01);       // fault enable
    cfg(0, 0, 0, 1, 0, 0); // auto select
    repeat (2) @(negedge clk);
    chk("R9 sck_oe in master", sck_oe, 1);
    chk("R6 ssel_oe auto", ssel_oe, 1);
    tog = 0;
    repeat (40) @(negedge clk);
    chk("R1 no sck without write", tog, 0);

    tog = 0;
    xfer(8'hA5, 8'h3C, 1);
    chk("R1 sixteen edges", tog, 16);
    chk("R6 ssel low during exchange", ss_mid, 0);
    chk("R6 ssel high after", ssel_o, 1);
    chk("R5 divisor 6", int'((t3 - t1) / 8.0), 6);
    rd(3'd3, v); chk("R10 done cleared by status+data", v[7], 0);

    cfg(0, 1, 0, 1, 0, 0); xfer(8'h96, 8'hE1, 1);
    cfg(1, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R2 idle high", sck, 1);
    xfer(8'h3B, 8'h7A, 1);
    cfg(1, 1, 0, 1, 0, 0); xfer(8'hC8, 8'h0F, 1);
    chk("R2 idle high after exchange", sck, 1);
    cfg(0, 0, 1, 1, 0, 0); xfer(8'h12, 8'hC4, 1);
    cfg(1, 1, 1, 1, 0, 0); xfer(8'h70, 8'h2D, 1);
    cfg(0, 0, 0, 1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R2 idle low", sck, 0);

    wr(3'd2, 8'h00); xfer(8'h5A, 8'h99, 1);
    chk("R5 divisor 2", int'((t3 - t1) / 8.0), 2);
    wr(3'd2, 8'h12); xfer(8'hE7, 8'h18, 1);
    chk("R5 divisor 16", int'((t3 - t1) / 8.0), 16);
    wr(3'd2, 8'h20);

    // R10: data read without a prior status read keeps done
    cfg(0, 0, 0, 1, 1, 0);
    xfer(8'h44, 8'hBD, 0);
    chk("R13 irq on done", irq, 1);
    rd(3'd4, v);
    rd(3'd3, v); chk("R10 done survives bare data read", v[7], 1);
    rd(3'd4, v);
    rd(3'd3, v); chk("R10 done cleared", v[7], 0);
    @(negedge clk);
    chk("R13 irq drops", irq, 0);

    // R11: write during exchange dropped
    tog = 0;
    launch(8'h6C, 8'hA3);
    repeat (8) @(negedge clk);
    rd(3'd3, v); chk("R11 empty clear while busy", v[5], 0);
    wr(3'd4, 8'hFF);
    wait_mon();
    repeat (40) @(negedge clk);
    chk("R11 extra write gives no edges", tog, 16);
    rd(3'd3, v); chk("R11 empty after", v[5], 1);
    rd(3'd4, v); chk("R11 data from first exchange", v, 8'hA3);

    // R12: abort
    tog = 0;
    wr(3'd4, 8'h55);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h20);
    repeat (3) @(negedge clk);
    chk("R12 sck idle after abort", sck, 0);
    chk("R12 ssel high after abort", ssel_o, 1);
    chk("R9 sck_oe off when disabled", sck_oe, 0);
    rd(3'd3, v); chk("R12 no done, empty", v, 8'h20);
    tog = 0;
    repeat (40) @(negedge clk);
    chk("R12 no further edges", tog, 0);

    cfg(0, 0, 0, 1, 0, 1);
    repeat (2) @(negedge clk);
    chk("R13 tx irq when empty", irq_tx, 1);

    // R7: select as input, fault
    cfg(0, 0, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    chk("R7 ssel_oe input mode", ssel_oe, 0);
    ssel_i = 0;
    repeat (6) @(negedge clk);
    chk("R7 irq on fault", irq, 1);
    rd(3'd3, v); chk("R7 fault flag", v[4], 1);
    rd(3'd0, v); chk("R7 master cleared", v[1], 0);
    chk("R9 sck_oe after fault", sck_oe, 0);
    ssel_i = 1;
    repeat (4) @(negedge clk);
    cfg(0, 0, 0, 0, 0, 0);
    rd(3'd3, v); chk("R10 fault cleared by status+ctrl1", v[4], 0);

    // R8: fault disabled, select ignored
    wr(3'd1, 8'h00);
    cfg(0, 0, 0, 1, 0, 0);
    ssel_i = 0;
    repeat (6) @(negedge clk);
    chk("R8 ssel_oe off", ssel_oe, 0);
    rd(3'd3, v); chk("R8 no fault", v[4], 0);
    rd(3'd0, v); chk("R8 master kept", v[1], 1);
    xfer(8'h81, 8'h7E, 1);
    chk("R8 ssel untouched", ss_mid, 1);
    ssel_i = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule